// File: doc/BRIEF.md
# PLL Reprogramming Delay Sequencer

This block steps a clock generator safely from one multiplier setting to another. A start request, taken only while the block is idle, begins a fixed series of steps. The output clock is switched to bypass and the block waits a programmed number of cycles. It then gives the PLL a one-cycle reset pulse and waits a second programmed count. Next it strobes the new multiplier word onto the setting output, waits a third programmed count for the loop to settle, and finally leaves bypass with a one-cycle done pulse.

The three wait counts and the next multiplier word are held in four write-only configuration registers. Their size is meant for settling times of tens of thousands of cycles. The multiplier word is captured when the request is accepted. After that, register traffic cannot change the word that the sequence applies.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, bypass, PLL reset, load strobe, busy and done are all low, and the setting output equals parameter MULT_RESET (default 0).
- R2: A write with cfg_addr 0 sets the bypass wait, 1 sets the reset wait, 2 sets the lock wait (low DLY_W bits of cfg_wdata), and 3 sets the next multiplier word (low MULT_W bits).
- R3: A start accepted at clock edge k makes bypass and busy high from the cycle after k (offset t=1). Bypass stays high until offset E-1, where E = 4 + Wb + Wr + Wl.
- R4: With Wb = max(bypass wait, 1), the PLL reset output is high exactly at offset t = 2 + Wb, for one cycle, while bypass is high.
- R5: With Wr = max(reset wait, 1), the load strobe is high exactly at offset t = 3 + Wb + Wr, for one cycle.
- R6: The setting output keeps its previous value through the load cycle and takes the captured word from offset t = 4 + Wb + Wr onward.
- R7: With Wl = max(lock wait, 1), done is high exactly at offset t = E, for one cycle. In that cycle busy is high and bypass is low, and busy is low from E+1.
- R8: A wait value of zero behaves as a one-cycle wait, the same as a value of one.
- R9: A start request while busy, including the done cycle, is ignored: the sequence timing does not change, and the block is idle at E+1.
- R10: The multiplier word is captured when start is accepted. A multiplier write in that same cycle is captured, and later multiplier writes do not change the word applied.
- R11: The wait counters cover at least 17 bits. Waits above 65535 cycles are timed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| start | input | 1 | Reprogramming request |
| pll_bypass | output | 1 | Output clock taken from the reference |
| pll_reset | output | 1 | PLL reset pulse |
| mult_load | output | 1 | One-cycle strobe applying the new word |
| mult_word | output | MULT_W | Applied multiplier setting |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on bypass release |

## Verification
Two pairs of events can fall in the same cycle. The first is a start request arriving in the done cycle. The second is a multiplier write arriving in the same cycle that a start is accepted. The bench sweeps all three waits over 0..3, so the zero and one cases sit next to longer ones. In chosen runs it raises start again on the first busy cycle and on the done cycle, writes the multiplier together with start, and writes a different word in mid-sequence. Every cycle of each run is compared with offsets computed from the programmed waits, and one long run sets a lock wait above 65535.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_BYP_ENTER = 3'd1,
      S_BYP_WAIT  = 3'd2,
      S_RST_PULSE = 3'd3,
      S_RST_WAIT  = 3'd4,
      S_WORD_LOAD = 3'd5,
      S_LOCK_WAIT = 3'd6,
      S_BYP_EXIT  = 3'd7
   } seq_state_e;

   localparam int NUM_WAITS = 3;
   localparam logic [1:0] A_WAIT_BYP  = 2'd0;
   localparam logic [1:0] A_WAIT_RST  = 2'd1;
   localparam logic [1:0] A_WAIT_LOCK = 2'd2;
   localparam logic [1:0] A_MULT      = 2'd3;

endpackage

// File: rtl/pllseq_cfg.sv
module pllseq_cfg #(
   parameter int DLY_W      = 20,
   parameter int MULT_W     = 8,
   parameter int DATA_W     = 20,
   parameter logic [MULT_W-1:0] MULT_RESET = '0
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        wr,
   input  logic [1:0]                                  addr,
   input  logic [DATA_W-1:0]                           wdata,
   input  logic                                        capture,
   input  logic                                        apply,
   output logic [pllseq_pkg::NUM_WAITS-1:0][DLY_W-1:0] waits,
   output logic [MULT_W-1:0]                           mult_word
);
   import pllseq_pkg::*;

   logic [MULT_W-1:0] mult_reg;
   logic [MULT_W-1:0] pending;
   logic              mult_hit;

   assign mult_hit = wr && (addr == A_MULT);

   for (genvar gi = 0; gi < NUM_WAITS; gi++) begin : g_wait
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            waits[gi] <= '0;
         else if (wr && (addr == 2'(gi)))
            waits[gi] <= wdata[DLY_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_reg  <= MULT_RESET;
         pending   <= MULT_RESET;
         mult_word <= MULT_RESET;
      end else begin
         if (mult_hit)
            mult_reg <= wdata[MULT_W-1:0];
         if (capture)
            pending <= mult_hit ? wdata[MULT_W-1:0] : mult_reg;
         if (apply)
            mult_word <= pending;
      end
   end

   a_r10_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(pending));
   a_r6_word_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(mult_word));

endmodule

// File: rtl/pllseq_dly_cnt.sv
module pllseq_dly_cnt #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec)
         cnt <= cnt - 1'b1;
   end

   // a count of zero or one ends the wait in the current cycle
   assign last = (cnt <= W'(1));

   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt > W'(1)));

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm #(
   parameter int DLY_W = 20
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        start,
   input  logic [pllseq_pkg::NUM_WAITS-1:0][DLY_W-1:0] waits,
   input  logic                                        cnt_last,
   output logic                                        cnt_load,
   output logic [DLY_W-1:0]                            cnt_val,
   output logic                                        cnt_dec,
   output logic                                        capture,
   output logic                                        bypass,
   output logic                                        pll_rst,
   output logic                                        load,
   output logic                                        busy,
   output logic                                        done
);
   import pllseq_pkg::*;

   seq_state_e state, nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= nxt;
   end

   always_comb begin
      nxt     = state;
      cnt_dec = 1'b0;
      unique case (state)
         S_IDLE:      if (start) nxt = S_BYP_ENTER;
         S_BYP_ENTER: nxt = S_BYP_WAIT;
         S_BYP_WAIT:  if (cnt_last) nxt = S_RST_PULSE; else cnt_dec = 1'b1;
         S_RST_PULSE: nxt = S_RST_WAIT;
         S_RST_WAIT:  if (cnt_last) nxt = S_WORD_LOAD; else cnt_dec = 1'b1;
         S_WORD_LOAD: nxt = S_LOCK_WAIT;
         S_LOCK_WAIT: if (cnt_last) nxt = S_BYP_EXIT; else cnt_dec = 1'b1;
         S_BYP_EXIT:  nxt = S_IDLE;
         default:     nxt = S_IDLE;
      endcase
   end

   always_comb begin
      cnt_load = 1'b1;
      cnt_val  = waits[0];
      unique case (state)
         S_BYP_ENTER: cnt_val = waits[0];
         S_RST_PULSE: cnt_val = waits[1];
         S_WORD_LOAD: cnt_val = waits[2];
         default:     cnt_load = 1'b0;
      endcase
   end

   assign capture = (state == S_IDLE) && start;
   assign busy    = (state != S_IDLE);
   assign bypass  = busy && (state != S_BYP_EXIT);
   assign pll_rst = (state == S_RST_PULSE);
   assign load    = (state == S_WORD_LOAD);
   assign done    = (state == S_BYP_EXIT);

   a_r3_bypass_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass) |-> $past(start) && !$past(busy));
   a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |=> !pll_rst);
   a_r4_rst_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |-> bypass);
   a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   a_r7_done_unbypassed: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy && !bypass);
   a_r9_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !capture);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq #(
   parameter int DLY_W  = 20,
   parameter int MULT_W = 8,
   parameter logic [MULT_W-1:0] MULT_RESET = '0,
   localparam int DATA_W = (DLY_W > MULT_W) ? DLY_W : MULT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              start,
   output logic              pll_bypass,
   output logic              pll_reset,
   output logic              mult_load,
   output logic [MULT_W-1:0] mult_word,
   output logic              busy,
   output logic              done
);
   import pllseq_pkg::*;

   if (DLY_W < 17) begin : g_bad_dly
      $error("DLY_W must be at least 17 for the expected settling waits");
   end
   if (MULT_W < 1) begin : g_bad_mult
      $error("MULT_W must be at least 1");
   end

   logic [NUM_WAITS-1:0][DLY_W-1:0] waits;
   logic             capture, cnt_load, cnt_dec, cnt_last;
   logic [DLY_W-1:0] cnt_val;

   pllseq_cfg #(
      .DLY_W(DLY_W), .MULT_W(MULT_W), .DATA_W(DATA_W), .MULT_RESET(MULT_RESET)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .capture(capture), .apply(mult_load), .waits(waits), .mult_word(mult_word)
   );

   pllseq_dly_cnt #(.W(DLY_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
      .dec(cnt_dec), .last(cnt_last)
   );

   pllseq_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .waits(waits),
      .cnt_last(cnt_last), .cnt_load(cnt_load), .cnt_val(cnt_val),
      .cnt_dec(cnt_dec), .capture(capture), .bypass(pll_bypass),
      .pll_rst(pll_reset), .load(mult_load), .busy(busy), .done(done)
   );

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pll_bypass && !pll_reset && !mult_load && !done);

endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
   localparam int DW = 20;
   localparam int MW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [1:0]    cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          start = 1'b0;
   logic          pll_bypass, pll_reset, mult_load, busy, done;
   logic [MW-1:0] mult_word;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   logic [MW-1:0] cur_word = '0;

   always #5 clk = ~clk;

   pll_reprog_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start(start), .pll_bypass(pll_bypass),
      .pll_reset(pll_reset), .mult_load(mult_load), .mult_word(mult_word),
      .busy(busy), .done(done)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, int d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // same: write word with start; midw: foreign word mid-run; spam: extra starts
   task automatic run(int nb, int nr, int nl, logic [MW-1:0] word,
                      bit same, bit midw, bit spam);
      int wb, wrr, wl, e;
      logic [MW-1:0] old;
      wb  = (nb == 0) ? 1 : nb;
      wrr = (nr == 0) ? 1 : nr;
      wl  = (nl == 0) ? 1 : nl;
      e   = 4 + wb + wrr + wl;
      old = cur_word;
      wr(2'd0, nb); wr(2'd1, nr); wr(2'd2, nl);   // R2 map
      if (!same) wr(2'd3, int'(word));
      start = 1'b1;
      if (same) begin cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = DW'(word); end
      @(negedge clk);
      start = 1'b0; cfg_wr = 1'b0;
      for (int t = 1; t <= e + 1; t++) begin
         chk("R3", "bypass", int'(pll_bypass), int'(t <= e - 1));
         chk("R7", "busy", int'(busy), int'(t <= e));
         chk("R4", "pll_reset", int'(pll_reset), int'(t == 2 + wb));
         chk("R5", "mult_load", int'(mult_load), int'(t == 3 + wb + wrr));
         chk("R7", "done", int'(done), int'(t == e));
         chk(same ? "R10" : "R6", "mult_word", int'(mult_word),
             int'((t >= 4 + wb + wrr) ? word : old));
         if (midw && t == 2) begin
            cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = DW'(~word);
         end
         if (spam && (t == 1 || t == e)) start = 1'b1;  // R9 ignored starts
         @(negedge clk);
         start = 1'b0; cfg_wr = 1'b0;
      end
      cur_word = word;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "bypass", int'(pll_bypass), 0);
      chk("R1", "pll_reset", int'(pll_reset), 0);
      chk("R1", "mult_load", int'(mult_load), 0);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "mult_word", int'(mult_word), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 zero/one waits and R9/R10 options spread through the sweep
      for (int nb = 0; nb < 4; nb++)
         for (int nr = 0; nr < 4; nr++)
            for (int nl = 0; nl < 4; nl++)
               run(nb, nr, nl, MW'(16 * nb + 4 * nr + nl + 1),
                   nb == 3, nr == 1, nl == 2);
      // R11 long wait beyond 16 bits
      run(1500, 12000, 70000, 8'hA5, 1'b0, 1'b1, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule